// File: doc/BRIEF.md
# Mailbox Command Sequencer with Readiness Gate

This block is a host-side bus master. It carries one command at a time through a doorbell mailbox that a device exposes as 64-bit registers. A requester pulses `start` with an opcode and an input length in bytes. The sequencer first acquires the mailbox. It polls the control register until the doorbell bit is clear, then reads the device status word and accepts the command only when the mailbox interface and the media both report ready and no fault is flagged.

Once the mailbox is acquired, the block writes the command register and copies the input payload from the requester's local buffer into the payload window. It then rings the doorbell and polls until the device clears it, within a bounded number of cycles. Next it reads the return code. Only on success does it read the output length and copy the output payload back into the local buffer. The outcome comes back on a one-cycle `done` pulse that carries an error class, the device return code and the output length.

Register byte offsets on the bus: device status 0x00, control/doorbell 0x08, command 0x10, mailbox status 0x18, and payload window from 0x40 in 8-byte words.

Top module: `mbx_seq`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `done`, `bus_req` and `buf_wr` are 0.
- R2: Every command first reads the control register (doorbell = bit 0) until it reads 0. It then reads the device status word once. The command goes ahead only if bit 4 (mailbox ready) is 1 and bits 3:2 (media state: 0 not ready, 1 ready, 2 error, 3 disabled) equal 1. Otherwise it ends with `err` = 1 (busy) and no command or doorbell write.
- R3: If the status word passes R2 but bit 0 (fatal), bit 1 (firmware halted) or bits 7:5 (reset request: 0 none, 1 cold, 2 warm, 3 hot, 4 link) are non-zero, the command ends with `err` = 3 (fault) and no command or doorbell write.
- R4: After a successful acquire, the sequencer issues these writes in order. First, the command register, with the opcode in bits 15:0 and the input length in bytes in bits 36:16. Second, ceil(len/8) payload words, where word k is taken from buffer address k. Third, a write of 1 to the control register. A zero input length produces no payload writes.
- R5: Each doorbell poll is bounded by `TIMEOUT` cycles. Once that limit has passed, the control register is sampled one more time. If the doorbell is still set, the command ends with `err` = 2 (timeout). This applies both to the acquire poll and to the completion poll. A completion timeout performs no return-code read.
- R6: After completion, the return code is read from bits 47:32 of the mailbox status register. If it is non-zero, `err` = 0, `ret_code` carries it, `out_len` = 0, and neither the command register nor the payload is read.
- R7: When the return code is zero, the command register is read, and bits 36:16 give `out_len`. Then ceil(out_len/8) payload words are read, and word k is written to buffer address k through `buf_wr`. A zero output length produces no payload reads.
- R8: `done` lasts exactly one cycle. In that cycle `err` (0 ok, 1 busy, 2 timeout, 3 fault), `ret_code` and `out_len` are valid. Every error ends with `ret_code` and `out_len` at 0.
- R9: A `start` pulse that arrives while a command is in progress is ignored. The running command keeps its opcode and length, and only one `done` is produced.
- R10: Once `bus_req` is raised, it stays high with a stable address and direction until `bus_ack` is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request pulse, accepted only when idle |
| opcode | input | 16 | Command opcode |
| in_len | input | LEN_W | Input payload length in bytes |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Error class: 0 ok, 1 busy, 2 timeout, 3 fault |
| ret_code | output | 16 | Device return code |
| out_len | output | LEN_W | Output payload length in bytes |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register byte address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 64 | Read data |
| buf_addr | output | LEN_W-2 | Local buffer word address |
| buf_rdata | input | 64 | Local buffer read data (combinational) |
| buf_wr | output | 1 | Local buffer write strobe |
| buf_wdata | output | 64 | Local buffer write data |

## Verification
The hardest case to reach is a doorbell that is already set when a command starts, since from the ports the sequencer only ever sees it in its idle-to-acquire transition. The bench's device model can arm the doorbell at the instant `start` is seen, with a chosen hold time. This drives both a delayed acquire and an acquire timeout. The readiness gate is swept over all 256 values of the status byte, with the expected busy/fault/ok class computed from the bit fields. Payload lengths are swept on both directions so that partial final words are covered.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

  typedef enum logic [1:0] {
    ERR_OK      = 2'd0,
    ERR_BUSY    = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_FAULT   = 2'd3
  } mbx_err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACQ_DB,
    S_STAT,
    S_CMD,
    S_PAYW,
    S_RING,
    S_WAIT_DB,
    S_RET,
    S_LEN,
    S_PAYR,
    S_DONE
  } seq_state_e;

  // register byte offsets
  localparam int unsigned OFS_DEVSTAT = 'h00;
  localparam int unsigned OFS_CTRL    = 'h08;
  localparam int unsigned OFS_CMD     = 'h10;
  localparam int unsigned OFS_MBSTAT  = 'h18;
  localparam int unsigned OFS_PAY     = 'h40;

  // field positions decoded by the device
  localparam int unsigned DB_BIT      = 0;
  localparam int unsigned CMD_LEN_LSB = 16;
  localparam int unsigned RC_LSB      = 32;

endpackage

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int unsigned LIMIT = 2000,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (en && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mbx_devstat_check.sv
module mbx_devstat_check (
  input  logic [7:0] status,
  output logic       ready,
  output logic       fault
);

  logic       if_ready;
  logic [1:0] media;
  logic [2:0] rst_req;

  assign if_ready = status[4];
  assign media    = status[3:2];
  assign rst_req  = status[7:5];

  assign ready = if_ready && (media == 2'd1);
  assign fault = status[0] || status[1] || (rst_req != 3'd0);

endmodule

// File: rtl/mbx_word_ctr.sv
module mbx_word_ctr #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] target,
  output logic [W-1:0] idx,
  output logic         last
);

  logic [W-1:0] idx_q, idx_d;

  assign idx  = idx_q;
  assign last = (idx_q == target - 1'b1);

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (inc) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned LEN_W   = 21,
  parameter int unsigned TIMEOUT = 2000,
  localparam int unsigned WC_W   = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       opcode,
  input  logic [LEN_W-1:0]  in_len,
  output logic              done,
  output logic [1:0]        err,
  output logic [15:0]       ret_code,
  output logic [LEN_W-1:0]  out_len,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [63:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [63:0]       bus_rdata,
  output logic [WC_W-1:0]   buf_addr,
  input  logic [63:0]       buf_rdata,
  output logic              buf_wr,
  output logic [63:0]       buf_wdata
);

  function automatic logic [WC_W-1:0] words_of(input logic [LEN_W-1:0] n);
    return WC_W'(({1'b0, n} + (LEN_W+1)'(7)) >> 3);
  endfunction

  seq_state_e        st_q, st_d;
  logic [15:0]       op_q;
  logic [LEN_W-1:0]  ilen_q;
  logic              last_q, last_d;
  mbx_err_e          err_q, err_d;
  logic [15:0]       ret_q, ret_d;
  logic [LEN_W-1:0]  olen_q, olen_d;

  logic              take;
  logic              poll, xfer;
  logic              tmr_exp;
  logic              dev_ready, dev_fault;
  logic [WC_W-1:0]   iwords, owords_q, owords_rd, wc_target, widx;
  logic              w_last;
  logic [LEN_W-1:0]  rd_len;
  logic [15:0]       rd_rc;

  assign take      = (st_q == S_IDLE) && start;
  assign poll      = (st_q == S_ACQ_DB) || (st_q == S_WAIT_DB);
  assign xfer      = (st_q == S_PAYW) || (st_q == S_PAYR);
  assign iwords    = words_of(ilen_q);
  assign owords_q  = words_of(olen_q);
  assign rd_len    = bus_rdata[CMD_LEN_LSB +: LEN_W];
  assign rd_rc     = bus_rdata[RC_LSB +: 16];
  assign owords_rd = words_of(rd_len);
  assign wc_target = (st_q == S_PAYR) ? owords_q : iwords;

  mbx_poll_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!poll),
    .en      (poll),
    .expired (tmr_exp)
  );

  mbx_devstat_check u_dev (
    .status (bus_rdata[7:0]),
    .ready  (dev_ready),
    .fault  (dev_fault)
  );

  mbx_word_ctr #(.W(WC_W)) u_wc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!xfer),
    .inc    (xfer && bus_ack),
    .target (wc_target),
    .idx    (widx),
    .last   (w_last)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    last_d = poll ? last_q : 1'b0;
    err_d  = err_q;
    ret_d  = ret_q;
    olen_d = olen_q;
    unique case (st_q)
      S_IDLE: if (start) begin
        st_d   = S_ACQ_DB;
        err_d  = ERR_OK;
        ret_d  = '0;
        olen_d = '0;
      end
      S_ACQ_DB, S_WAIT_DB: if (bus_ack) begin
        if (!bus_rdata[DB_BIT]) begin
          st_d = (st_q == S_ACQ_DB) ? S_STAT : S_RET;
        end else if (last_q) begin
          st_d  = S_DONE;
          err_d = ERR_TIMEOUT;
        end else if (tmr_exp) begin
          last_d = 1'b1;
        end
      end
      S_STAT: if (bus_ack) begin
        if (!dev_ready) begin
          st_d  = S_DONE;
          err_d = ERR_BUSY;
        end else if (dev_fault) begin
          st_d  = S_DONE;
          err_d = ERR_FAULT;
        end else begin
          st_d = S_CMD;
        end
      end
      S_CMD:  if (bus_ack) st_d = (iwords != '0) ? S_PAYW : S_RING;
      S_PAYW: if (bus_ack && w_last) st_d = S_RING;
      S_RING: if (bus_ack) st_d = S_WAIT_DB;
      S_RET: if (bus_ack) begin
        ret_d = rd_rc;
        st_d  = (rd_rc != 16'd0) ? S_DONE : S_LEN;
      end
      S_LEN: if (bus_ack) begin
        olen_d = rd_len;
        st_d   = (owords_rd != '0) ? S_PAYR : S_DONE;
      end
      S_PAYR: if (bus_ack && w_last) st_d = S_DONE;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // state and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      last_q <= 1'b0;
      err_q  <= ERR_OK;
      ret_q  <= '0;
      olen_q <= '0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
      err_q  <= err_d;
      ret_q  <= ret_d;
      olen_q <= olen_d;
    end
  end

  // request capture, enabled only when accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      ilen_q <= '0;
    end else if (take) begin
      op_q   <= opcode;
      ilen_q <= in_len;
    end
  end

  // bus drive
  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st_q)
      S_ACQ_DB, S_WAIT_DB: bus_addr = ADDR_W'(OFS_CTRL);
      S_STAT:              bus_addr = ADDR_W'(OFS_DEVSTAT);
      S_CMD: begin
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(OFS_CMD);
        bus_wdata = 64'(op_q) | (64'(ilen_q) << CMD_LEN_LSB);
      end
      S_PAYW: begin
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(OFS_PAY) + ADDR_W'({widx, 3'b000});
        bus_wdata = buf_rdata;
      end
      S_RING: begin
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(OFS_CTRL);
        bus_wdata = 64'd1 << DB_BIT;
      end
      S_RET:  bus_addr = ADDR_W'(OFS_MBSTAT);
      S_LEN:  bus_addr = ADDR_W'(OFS_CMD);
      S_PAYR: bus_addr = ADDR_W'(OFS_PAY) + ADDR_W'({widx, 3'b000});
      default: bus_req = 1'b0;
    endcase
  end

  assign buf_addr  = widx;
  assign buf_wr    = (st_q == S_PAYR) && bus_ack;
  assign buf_wdata = bus_rdata;

  assign done     = (st_q == S_DONE);
  assign err      = err_q;
  assign ret_code = ret_q;
  assign out_len  = olen_q;

endmodule

// File: rtl/mbx_seq_chk.sv
module mbx_seq_chk
  import mbx_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [1:0]        err,
  input logic [15:0]       ret_code,
  input logic [LEN_W-1:0]  out_len,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              buf_wr
);

  // R8: completion pulse lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: error outcomes carry no return code and no length
  p_err_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err != ERR_OK) |-> (ret_code == 16'd0 && out_len == '0));

  // R6: a non-zero return code reports no output length
  p_rc_nolen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ret_code != 16'd0) |-> (out_len == '0 && err == ERR_OK));

  // R10: request held steady until acknowledged
  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R7: buffer writes only on an acknowledged payload read
  p_bufwr_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> (bus_ack && !bus_we && bus_addr >= ADDR_W'(OFS_PAY)));

  // R1: outputs quiet during reset
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!done && !bus_req && !buf_wr);
    end
  end

endmodule

bind mbx_seq mbx_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .err      (err),
  .ret_code (ret_code),
  .out_len  (out_len),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_ack  (bus_ack),
  .buf_wr   (buf_wr)
);

// File: tb/mbx_seq_tb.sv
module mbx_seq_tb;
  import mbx_seq_pkg::*;

  localparam int unsigned AW  = 16;
  localparam int unsigned LW  = 21;
  localparam int unsigned TMO = 40;
  localparam int unsigned WCW = LW - 2;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic          start;
  logic [15:0]   opcode;
  logic [LW-1:0] in_len;
  logic          done;
  logic [1:0]    err;
  logic [15:0]   ret_code;
  logic [LW-1:0] out_len;
  logic          bus_req, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [63:0]   bus_wdata, bus_rdata;
  logic [WCW-1:0] buf_addr;
  logic [63:0]   buf_rdata, buf_wdata;
  logic          buf_wr;

  mbx_seq #(.ADDR_W(AW), .LEN_W(LW), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .in_len(in_len),
    .done(done), .err(err), .ret_code(ret_code), .out_len(out_len),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata)
  );

  // ---------------- device and buffer model ----------------
  logic [63:0] cfg_stat;
  int          cfg_lat, cfg_pre;
  logic [15:0] cfg_rc;
  logic [LW-1:0] cfg_olen;
  logic [31:0] cfg_seed;

  logic [63:0] in_buf  [32];
  logic [63:0] out_buf [32];
  logic [63:0] pay_mem [32];
  logic        db, from_ring, ack_q, pend_q;
  int          db_cnt;
  logic [63:0] cmd_reg, rc_reg, last_cmdw, rdata_q;
  logic [AW-1:0] paddr_q;
  int n_cmdw, n_payw, n_ring, n_payr, n_lenr, n_retr, n_done, n_viol;
  logic [4:0] pidx;

  function automatic logic [63:0] pat(input logic [31:0] seed, input int k);
    return {seed, 32'(k)};
  endfunction

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign buf_rdata = in_buf[buf_addr[4:0]];
  assign pidx      = 5'((bus_addr - AW'(OFS_PAY)) >> 3);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0; db <= 1'b0; db_cnt <= 0; from_ring <= 1'b0;
      cmd_reg <= '0; rc_reg <= '0; last_cmdw <= '0; rdata_q <= '0;
      pend_q <= 1'b0; paddr_q <= '0;
      n_cmdw <= 0; n_payw <= 0; n_ring <= 0; n_payr <= 0;
      n_lenr <= 0; n_retr <= 0; n_done <= 0; n_viol <= 0;
    end else begin
      ack_q   <= 1'b0;
      pend_q  <= bus_req && !bus_ack;
      paddr_q <= bus_addr;
      if (pend_q && (!bus_req || bus_addr != paddr_q)) n_viol <= n_viol + 1;
      if (done) n_done <= n_done + 1;
      if (start && cfg_pre != 0 && !db) begin
        db <= 1'b1; db_cnt <= cfg_pre; from_ring <= 1'b0;
      end else if (db) begin
        if (db_cnt == 0) begin
          db <= 1'b0;
          if (from_ring) begin
            cmd_reg[CMD_LEN_LSB +: LW] <= cfg_olen;
            rc_reg <= {16'd0, cfg_rc, 32'd0};
          end
        end else db_cnt <= db_cnt - 1;
      end
      if (bus_req && !ack_q) begin
        ack_q <= 1'b1;
        if (bus_we) begin
          if (bus_addr == AW'(OFS_CMD)) begin
            cmd_reg <= bus_wdata; last_cmdw <= bus_wdata; n_cmdw <= n_cmdw + 1;
          end else if (bus_addr == AW'(OFS_CTRL)) begin
            if (bus_wdata[0]) begin
              db <= 1'b1; db_cnt <= cfg_lat; from_ring <= 1'b1; n_ring <= n_ring + 1;
            end
          end else begin
            pay_mem[pidx] <= bus_wdata; n_payw <= n_payw + 1;
          end
        end else begin
          if (bus_addr == AW'(OFS_DEVSTAT))      rdata_q <= cfg_stat;
          else if (bus_addr == AW'(OFS_CTRL))    rdata_q <= {63'd0, db};
          else if (bus_addr == AW'(OFS_CMD))   begin rdata_q <= cmd_reg; n_lenr <= n_lenr + 1; end
          else if (bus_addr == AW'(OFS_MBSTAT)) begin rdata_q <= rc_reg;  n_retr <= n_retr + 1; end
          else begin rdata_q <= pat(cfg_seed, int'(pidx)); n_payr <= n_payr + 1; end
        end
      end
      if (buf_wr) out_buf[buf_addr[4:0]] <= buf_wdata;
    end
  end

  // ---------------- checking infrastructure ----------------
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  logic [1:0]    r_err;
  logic [15:0]   r_ret;
  logic [LW-1:0] r_olen;
  int s_cmdw, s_payw, s_ring, s_payr, s_lenr, s_retr, s_done;

  task automatic run(input logic [15:0] op, input logic [LW-1:0] len, input bit poke);
    int w;
    s_cmdw = n_cmdw; s_payw = n_payw; s_ring = n_ring; s_payr = n_payr;
    s_lenr = n_lenr; s_retr = n_retr; s_done = n_done;
    @(negedge clk); start = 1'b1; opcode = op; in_len = len;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1; opcode = 16'hBEEF; in_len = LW'(8);
      @(negedge clk); start = 1'b0; opcode = op; in_len = len;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done, "R8 done seen", longint'(done), 1);
    r_err = err; r_ret = ret_code; r_olen = out_len;
    @(negedge clk);
    chk(!done, "R8 done single cycle", longint'(done), 0);
  endtask

  function automatic int words(input int n);
    return (n + 7) / 8;
  endfunction

  task automatic check_ok_xfer(input int il, input int ol, input logic [15:0] op, input string tag);
    chk(r_err == ERR_OK, {tag, " R4 err"}, r_err, 0);
    chk(r_olen == LW'(ol), {tag, " R7 out_len"}, r_olen, ol);
    chk(last_cmdw[15:0] == op, {tag, " R4 opcode field"}, last_cmdw[15:0], op);
    chk(last_cmdw[36:16] == 21'(il), {tag, " R4 length field"}, last_cmdw[36:16], il);
    chk(n_payw - s_payw == words(il), {tag, " R4 payload writes"}, n_payw - s_payw, words(il));
    chk(n_ring - s_ring == 1, {tag, " R4 doorbell"}, n_ring - s_ring, 1);
    chk(n_payr - s_payr == words(ol), {tag, " R7 payload reads"}, n_payr - s_payr, words(ol));
    for (int k = 0; k < words(il); k++)
      chk(pay_mem[k] == in_buf[k], {tag, " R4 payload word"}, pay_mem[k], in_buf[k]);
    for (int k = 0; k < words(ol); k++)
      chk(out_buf[k] == pat(cfg_seed, k), {tag, " R7 buffer word"}, out_buf[k], pat(cfg_seed, k));
  endtask

  // ---------------- stimulus ----------------
  initial begin
    for (int k = 0; k < 32; k++) in_buf[k] = {32'hC0DE_0000 | 32'(k), 32'(k * 13 + 5)};
    start = 1'b0; opcode = '0; in_len = '0;
    cfg_stat = 64'h14; cfg_lat = 5; cfg_pre = 0; cfg_rc = '0; cfg_olen = '0; cfg_seed = 32'd1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !bus_req && !buf_wr, "R1 quiet in reset", {done, bus_req, buf_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !bus_req && !buf_wr, "R1 quiet after reset", {done, bus_req, buf_wr}, 0);

    // identify-style command: no input, 48-byte answer
    cfg_olen = LW'(48); cfg_seed = 32'hA1;
    run(16'h4000, '0, 1'b0);
    check_ok_xfer(0, 48, 16'h4000, "ident");

    // length sweep in both directions
    for (int i = 0; i <= 24; i++) begin
      cfg_olen = LW'(120 - i * 5); cfg_seed = 32'h100 + 32'(i);
      run(16'h0200 + 16'(i), LW'(i * 5), 1'b0);
      check_ok_xfer(i * 5, 120 - i * 5, 16'h0200 + 16'(i), "sweep");
    end

    // non-zero return code
    cfg_rc = 16'h0017; cfg_olen = LW'(64);
    run(16'h0301, LW'(8), 1'b0);
    chk(r_err == ERR_OK, "R6 err", r_err, 0);
    chk(r_ret == 16'h0017, "R6 ret_code", r_ret, 16'h17);
    chk(r_olen == '0, "R6 out_len", r_olen, 0);
    chk(n_lenr == s_lenr && n_payr == s_payr, "R6 no length/payload read",
        n_lenr - s_lenr + n_payr - s_payr, 0);
    chk(n_retr - s_retr == 1, "R6 one return read", n_retr - s_retr, 1);
    cfg_rc = '0; cfg_olen = '0;

    // completion timeout, then a slow but in-bound completion
    cfg_lat = 100;
    run(16'h0400, '0, 1'b0);
    chk(r_err == ERR_TIMEOUT, "R5 completion timeout", r_err, 2);
    chk(n_retr == s_retr, "R5 no return read", n_retr - s_retr, 0);
    repeat (150) @(negedge clk);
    cfg_lat = TMO - 8;
    run(16'h0401, '0, 1'b0);
    chk(r_err == ERR_OK, "R5 slow completion in bound", r_err, 0);
    cfg_lat = 5;

    // doorbell already busy at start
    cfg_pre = 12;
    run(16'h0500, '0, 1'b0);
    chk(r_err == ERR_OK, "R2 delayed acquire", r_err, 0);
    chk(n_ring - s_ring == 1, "R2 delayed acquire rings", n_ring - s_ring, 1);
    cfg_pre = 1000;
    run(16'h0501, '0, 1'b0);
    chk(r_err == ERR_TIMEOUT, "R5 acquire timeout", r_err, 2);
    chk(n_cmdw == s_cmdw, "R5 no command write", n_cmdw - s_cmdw, 0);
    cfg_pre = 0;
    repeat (1100) @(negedge clk);

    // exhaustive readiness gate over the status byte
    cfg_lat = 2;
    for (int s = 0; s < 256; s++) begin
      logic [7:0] sb;
      logic [1:0] exp_e;
      sb = 8'(s);
      cfg_stat = 64'(sb);
      if (!(sb[4] && sb[3:2] == 2'd1))              exp_e = ERR_BUSY;
      else if (sb[0] || sb[1] || sb[7:5] != 3'd0)   exp_e = ERR_FAULT;
      else                                          exp_e = ERR_OK;
      run(16'h0600, '0, 1'b0);
      if (exp_e == ERR_FAULT)
        chk(r_err == exp_e, "R3 fault class", r_err, exp_e);
      else
        chk(r_err == exp_e, "R2 ready class", r_err, exp_e);
      chk((n_ring - s_ring) == ((exp_e == ERR_OK) ? 1 : 0) &&
          (n_cmdw - s_cmdw) == ((exp_e == ERR_OK) ? 1 : 0),
          "R2 R3 submit only when ready", n_ring - s_ring, (exp_e == ERR_OK) ? 1 : 0);
    end
    cfg_stat = 64'h14; cfg_lat = 5;

    // start while busy is ignored
    cfg_olen = LW'(16); cfg_seed = 32'h77;
    run(16'h2222, LW'(16), 1'b1);
    repeat (20) @(negedge clk);
    chk(n_done - s_done == 1, "R9 single done", n_done - s_done, 1);
    chk(last_cmdw[15:0] == 16'h2222, "R9 opcode kept", last_cmdw[15:0], 16'h2222);
    chk(n_cmdw - s_cmdw == 1, "R9 one command write", n_cmdw - s_cmdw, 1);
    check_ok_xfer(16, 16, 16'h2222, "busy-start");

    chk(n_viol == 0, "R10 request held until ack", n_viol, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule